// File: doc/BRIEF.md
# Single-Cycle 8-bit Register-Machine Core

This core runs one instruction per clock. Its program counter drives an external combinational program store. The store returns the instruction word in the same cycle, and the core executes that word at the next rising edge. The two top bits of the word pick one of four classes:

- a 6-bit immediate load into r0,
- a register-to-register copy,
- an ALU operation with fixed operands r3 = f(r1, r2),
- a conditional branch that tests r3 and takes its target from r0.

There are six general registers, r0 to r5. Index 6 in a copy is the I/O window: as a source it reads the input port, and as a destination it writes the output port.

An undefined program word reads as 0x00, which executes as "r0 = 0". A program placed from address 1 therefore starts cleanly after reset, because the word at address 0 does nothing harmful.

Top module: `cpu8_core`

## Requirements
- R1: Bits [7:6] of the instruction give the class: 00 load immediate, 01 ALU, 10 copy, 11 branch. A load-immediate word writes {2'b00, bits[5:0]} into r0, so 0x00 clears r0.
- R2: A copy word (10 sss ddd) writes the value of source index sss into destination index ddd. Indices 0 to 5 are r0 to r5.
- R3: In a copy, source index 6 reads in_i and destination index 6 writes out_o. The output port holds its value until the next such write.
- R4: Index 7 in either field of a copy makes the whole word a no-op. No register and no output changes, and no strobe fires.
- R5: An ALU word (01 xxx ccc) writes to r3. Code 100 gives r1 + r2 and code 101 gives r1 - r2, both modulo 256.
- R6: The ALU codes 000, 001, 010 and 011 give OR, NAND, NOR and AND of r1 and r2. Codes 110 and 111 leave r3 unchanged.
- R7: A branch word (11 xxx ccc) with ccc = 001 loads pc from r0 when r3 is zero. Otherwise pc advances by one.
- R8: The other branch codes test r3 as a signed value: 000 never, 010 less than zero, 011 less or equal, 100 always, 101 not zero, 110 greater or equal, 111 greater than zero.
- R9: When no branch is taken, pc advances by one per clock and wraps from 255 to 0.
- R10: While rst_ni is low, pc, r0 to r5, out_o and out_valid_o are zero.
- R11: out_valid_o is high for exactly the one cycle after each write to the output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 8 | Instruction word from the program store at pc_o |
| pc_o | output | 8 | Program counter, the address into the program store |
| in_i | input | 8 | External input port, read through copy index 6 |
| out_o | output | 8 | External output port, written through copy index 6 |
| out_valid_o | output | 1 | One-cycle strobe after each output-port write |

## Verification
A fault in the program counter shows on pc_o at the very next edge. A mis-decoded branch condition also shows there, as a target address where pc+1 was due, or the reverse.

A corrupted general register stays invisible until a copy routes it, directly or through r3 by way of the ALU, to the output port. It then appears on out_o one cycle after that copy, together with the strobe. The bench therefore moves every computed value to out_o straight after it is produced, so each register fault shows within two cycles of its cause.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned NREG    = 6;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned IO_IDX  = 6;
  localparam int unsigned NOP_IDX = 7;

  typedef enum logic [1:0] {
    CL_LDI = 2'b00,
    CL_ALU = 2'b01,
    CL_MOV = 2'b10,
    CL_BR  = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    OP_OR = 3'b000, OP_NAND = 3'b001, OP_NOR = 3'b010, OP_AND = 3'b011,
    OP_ADD = 3'b100, OP_SUB = 3'b101, OP_KEEP0 = 3'b110, OP_KEEP1 = 3'b111
  } aluop_e;

  typedef enum logic [2:0] {
    CC_NEVER = 3'b000, CC_EQ = 3'b001, CC_LT = 3'b010, CC_LE = 3'b011,
    CC_ALWAYS = 3'b100, CC_NE = 3'b101, CC_GE = 3'b110, CC_GT = 3'b111
  } cond_e;
endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  aluop_e       op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_OR:   y_o = a_i | b_i;
      OP_NAND: y_o = ~(a_i & b_i);
      OP_NOR:  y_o = ~(a_i | b_i);
      OP_AND:  y_o = a_i & b_i;
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      default: y_o = keep_i;
    endcase
  end
endmodule

// File: rtl/cpu8_cond.sv
module cpu8_cond
  import cpu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  cond_e        cc_i,
  input  logic [W-1:0] v_i,
  output logic         take_o
);
  logic neg, zero;
  assign neg  = v_i[W-1];
  assign zero = (v_i == '0);

  always_comb begin
    unique case (cc_i)
      CC_NEVER:  take_o = 1'b0;
      CC_EQ:     take_o = zero;
      CC_LT:     take_o = neg;
      CC_LE:     take_o = neg | zero;
      CC_ALWAYS: take_o = 1'b1;
      CC_NE:     take_o = ~zero;
      CC_GE:     take_o = ~neg;
      default:   take_o = ~neg & ~zero;
    endcase
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
  import cpu8_pkg::*;
#(
  parameter int unsigned W     = DW,
  parameter int unsigned N     = NREG,
  parameter int unsigned IW    = IDX_W,
  parameter int unsigned IO    = IO_IDX,
  parameter int unsigned NOP   = NOP_IDX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ldi_we_i,
  input  logic [W-1:0]  ldi_val_i,
  input  logic          mov_we_i,
  input  logic [IW-1:0] src_i,
  input  logic [IW-1:0] dst_i,
  input  logic [W-1:0]  in_i,
  input  logic          alu_we_i,
  input  logic [W-1:0]  alu_y_i,
  output logic [W-1:0]  r0_o,
  output logic [W-1:0]  r1_o,
  output logic [W-1:0]  r2_o,
  output logic [W-1:0]  r3_o,
  output logic [W-1:0]  out_o,
  output logic          out_valid_o
);
  logic [W-1:0] rf_q [N];
  logic [W-1:0] src_val;
  logic         mov_ok;

  always_comb begin
    src_val = '0;
    for (int k = 0; k < N; k++)
      if (src_i == IW'(k)) src_val = rf_q[k];
    if (src_i == IW'(IO)) src_val = in_i;
  end

  // index 7 on either side voids the copy
  assign mov_ok = mov_we_i && (src_i != IW'(NOP)) && (dst_i != IW'(NOP));

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       rf_q[i] <= '0;
      else if (i == 0 && ldi_we_i)       rf_q[i] <= ldi_val_i;
      else if (i == 3 && alu_we_i)       rf_q[i] <= alu_y_i;
      else if (mov_ok && dst_i == IW'(i)) rf_q[i] <= src_val;
    end
  end

  logic out_we;
  assign out_we = mov_ok && (dst_i == IW'(IO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= out_we;
      if (out_we) out_o <= src_val;
    end
  end

  assign r0_o = rf_q[0];
  assign r1_o = rf_q[1];
  assign r2_o = rf_q[2];
  assign r3_o = rf_q[3];

  // R3/R11: output moves only when the strobe marks a write
  assert_out_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_o));
  // R4: a copy naming index 7 leaves r3 untouched
  assert_nop_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mov_we_i && (src_i == IW'(NOP) || dst_i == IW'(NOP))) |=> $stable(r3_o));
  // R1: immediate load never sets the top two bits of r0
  assert_ldi_zext_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldi_we_i |=> (r0_o[W-1:W-2] == 2'b00));
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] instr_i,
  output logic [W-1:0] pc_o,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o,
  output logic         out_valid_o
);
  cls_e         cls;
  aluop_e       aop;
  cond_e        cc;
  logic [W-1:0] r0, r1, r2, r3, alu_y;
  logic         take, br_taken;
  logic [W-1:0] pc_q;

  assign cls = cls_e'(instr_i[7:6]);
  assign aop = aluop_e'(instr_i[2:0]);
  assign cc  = cond_e'(instr_i[2:0]);

  cpu8_alu #(.W(W)) u_alu (
    .op_i(aop), .a_i(r1), .b_i(r2), .keep_i(r3), .y_o(alu_y)
  );

  cpu8_cond #(.W(W)) u_cond (
    .cc_i(cc), .v_i(r3), .take_o(take)
  );

  cpu8_regfile #(.W(W)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ldi_we_i    (cls == CL_LDI),
    .ldi_val_i   ({2'b00, instr_i[5:0]}),
    .mov_we_i    (cls == CL_MOV),
    .src_i       (instr_i[5:3]),
    .dst_i       (instr_i[2:0]),
    .in_i        (in_i),
    .alu_we_i    (cls == CL_ALU),
    .alu_y_i     (alu_y),
    .r0_o        (r0),
    .r1_o        (r1),
    .r2_o        (r2),
    .r3_o        (r3),
    .out_o       (out_o),
    .out_valid_o (out_valid_o)
  );

  assign br_taken = (cls == CL_BR) && take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (br_taken) pc_q <= r0;
    else               pc_q <= pc_q + W'(1);
  end

  assign pc_o = pc_q;

  // R9: sequential step, including 255 -> 0
  assert_pc_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls != CL_BR) |=> pc_o == W'($past(pc_o) + W'(1)));
  // R7: zero test with code 001 picks the branch target from r0
  assert_br_eq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_BR && cc == CC_EQ && r3 == '0) |=> pc_o == $past(r0));
  // R8: never / always codes
  assert_br_never_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_BR && cc == CC_NEVER) |=> pc_o == W'($past(pc_o) + W'(1)));
  assert_br_always_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_BR && cc == CC_ALWAYS) |=> pc_o == $past(r0));
  // R6: hold codes keep r3
  assert_alu_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_ALU && instr_i[2:1] == 2'b11) |=> $stable(r3));
  // R5: add result lands in r3
  assert_alu_add_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_ALU && aop == OP_ADD) |=> r3 == W'($past(r1) + $past(r2)));
endmodule

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;
  localparam time CLK_P = 4ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] instr_i = 8'h00;
  logic [7:0] in_i = 8'h00;
  logic [7:0] pc_o, out_o;
  logic       out_valid_o;

  int errs = 0;
  int chks = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cpu8_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .pc_o(pc_o),
    .in_i(in_i), .out_o(out_o), .out_valid_o(out_valid_o)
  );

  // fields: a[31:24] b[23:16] op[15:8] expected[7:0]
  localparam logic [31:0] ALU_VEC [8] = '{
    32'h050A_040F, 32'hF020_0410, 32'h0A0F_05FB, 32'h3010_0520,
    32'hF00F_00FF, 32'hCCAA_0177, 32'hCCAA_0211, 32'hCCAA_0388
  };
  localparam logic [7:0] BR_VAL  [3] = '{8'h80, 8'h00, 8'h05};
  localparam logic [7:0] BR_MASK [3] = '{8'h3C, 8'h5A, 8'hF0};

  localparam logic [7:0] I_IN_R1  = 8'hB1, I_IN_R2 = 8'hB2, I_IN_R0 = 8'hB0;
  localparam logic [7:0] I_R3_OUT = 8'h9E, I_R0_OUT = 8'h86, I_R4_OUT = 8'hA6;
  localparam logic [7:0] I_IN_OUT = 8'hB6, I_NOP77 = 8'hBF, I_R7_OUT = 8'hBE;
  localparam logic [7:0] I_R0_R7  = 8'h87, I_R0_R5 = 8'h85, I_R5_OUT = 8'hAE;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [7:0] ins, input logic [7:0] din = 8'h00);
    instr_i = ins;
    in_i    = din;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic [7:0] pc_before;
    repeat (3) @(posedge clk_i);
    #1;
    // R10: reset state
    check("R10 pc", pc_o, 8'h00);
    check("R10 out", out_o, 8'h00);
    check("R10 valid", {7'b0, out_valid_o}, 8'h00);
    rst_ni = 1'b1;
    exec(I_IN_OUT, 8'h5A);
    check("R3 in->out", out_o, 8'h5A);
    check("R11 strobe", {7'b0, out_valid_o}, 8'h01);
    check("R9 pc step", pc_o, 8'h01);
    exec(I_R4_OUT);
    check("R10 r4 zero", out_o, 8'h00);

    // R5/R6: table walk
    for (int i = 0; i < 8; i++) begin
      exec(I_IN_R1, ALU_VEC[i][31:24]);
      exec(I_IN_R2, ALU_VEC[i][23:16]);
      exec(8'h40 | ALU_VEC[i][15:8]);
      exec(I_R3_OUT);
      check(ALU_VEC[i][10] ? "R5 alu" : "R6 alu", out_o, ALU_VEC[i][7:0]);
      check("R11 strobe", {7'b0, out_valid_o}, 8'h01);
    end
    // R6: hold codes (r3 = 88 from last vector); bits 5:3 ignored
    exec(I_IN_R1, 8'h01);
    exec(8'h7E);
    exec(8'h47);
    exec(I_R3_OUT);
    check("R6 keep", out_o, 8'h88);

    // R11: strobe drops after one cycle
    exec(I_NOP77);
    check("R11 one cycle", {7'b0, out_valid_o}, 8'h00);
    check("R4 nop out", out_o, 8'h88);

    // R4: index 7 as source or destination
    exec(I_R7_OUT);
    check("R4 src7 out", out_o, 8'h88);
    check("R4 src7 strobe", {7'b0, out_valid_o}, 8'h00);
    exec(8'h2B);
    exec(I_R0_R7);
    check("R4 dst7 strobe", {7'b0, out_valid_o}, 8'h00);

    // R1: immediate and clear
    exec(8'h3F);
    exec(I_R0_OUT);
    check("R1 ldi", out_o, 8'h3F);
    exec(8'h00);
    exec(I_R0_OUT);
    check("R1 clear", out_o, 8'h00);
    // R2: chain r0 -> r5 -> out
    exec(8'h15);
    exec(I_R0_R5);
    exec(8'h00);
    exec(I_R5_OUT);
    check("R2 copy", out_o, 8'h15);

    // R7/R8: every condition against negative, zero, positive r3
    for (int v = 0; v < 3; v++) begin
      for (int c = 0; c < 8; c++) begin
        exec(I_IN_R1, BR_VAL[v]);
        exec(I_IN_R2, 8'h00);
        exec(8'h44);
        exec(8'h2A);
        pc_before = pc_o;
        exec(8'hC0 | 8'(c));
        check(c == 1 ? "R7 branch" : "R8 branch", pc_o,
              BR_MASK[v][c] ? 8'h2A : 8'(pc_before + 8'h01));
      end
    end

    // R9: wrap 255 -> 0 (r3 = 05)
    exec(I_IN_R0, 8'hFF);
    exec(8'hC4);
    check("R9 jump ff", pc_o, 8'hFF);
    exec(I_NOP77);
    check("R9 wrap", pc_o, 8'h00);

    // R10: async reset mid-run
    exec(I_IN_OUT, 8'h77);
    #1 rst_ni = 1'b0;
    #1;
    check("R10 pc mid", pc_o, 8'h00);
    check("R10 out mid", out_o, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule